// File: doc/BRIEF.md
# Bidirectional Cascadable Sampling-Pulse Sequencer

This block produces the column sampling strobes for one column-driver chip in a chain of such chips. A start pin sits at each end of the chip, and each pin can act as input or output. A direction input picks which end receives the start pulse. The other end carries the cascade pulse to the next chip in the chain. The unused direction of each pin is modelled as a separate output value plus an output-enable.

Once the start pulse has been captured, a single token walks through a 100-stage scan, one stage per clock. Each stage strobes three adjacent columns together, so the full scan covers 300 columns. A reduced-width mode drops a centred band of four stages (columns 145 to 156), so the scan covers 288 columns. In that mode the band's strobes are copies of the neighbouring group that is scanned on the far side of the band.

No data stream passes through the block. All pins are plain control pins with no handshake.

Top module: `colscan_seq`

## Requirements
- R1: A synchronous active-high `rst` clears all strobes and deasserts both `sp_left_oe` and `sp_right_oe`, and with them both cascade outputs. In the cycle after any clock edge where `rst` is high, every one of these outputs is 0.
- R2: A scan starts when the selected start pin is high at a rising clock edge after being low at the previous edge. The first group then strobes in the next cycle. A pin held high for many cycles starts only one scan and does not delay the first strobe. A pin that is already high when reset releases starts nothing.
- R3: With `dir_fwd`=1 the start input is `sp_right_in`. Columns are strobed in ascending order, three per cycle: bits 0..2 of `col_strobe` (columns 1..3) first and bits 297..299 last.
- R4: With `dir_fwd`=0 the start input is `sp_left_in`. Columns are strobed in descending order: bits 297..299 first and bits 0..2 last.
- R5: Column c (1-based) is driven by stage (c-1)/3, so the three columns of a stage always strobe together. Exactly one stage is strobed per cycle during a scan, apart from the mirrored band of R7, and no strobe is high when idle.
- R6: With `full_mode`=0, columns 145..156 (bits 144..155) are skipped in scan order. A scan then lasts 96 cycles instead of 100. Rightward, columns 157..159 follow 142..144 directly. Leftward, columns 142..144 follow 157..159 directly.
- R7: With `full_mode`=0, columns 145..156 repeat the strobes of columns 157..168 when `dir_fwd`=1, and of columns 133..144 when `dir_fwd`=0, with an offset of 12 columns.
- R8: The cascade output of the far end is high during exactly the cycle in which the final group strobes: `sp_left_out` when rightward, `sp_right_out` when leftward. A following chip therefore strobes its first group in the very next cycle, with no gap.
- R9: One cycle after each edge, `sp_left_oe` equals `dir_fwd` and `sp_right_oe` equals its inverse, unless `rst` was high. The two enables are never high together, and an output whose enable is low stays 0.
- R10: A new start event during a scan restarts the scan from the first group in the next cycle and drops the old position.
- R11: The start pin that is not selected by `dir_fwd` has no effect on strobes or cascade outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| dir_fwd | input | 1 | 1: rightward scan from the right pin; 0: leftward from the left pin |
| full_mode | input | 1 | 1: 300 columns; 0: 288 columns with the centre band bypassed |
| sp_right_in | input | 1 | Right-end start pin, input value |
| sp_right_out | output | 1 | Right-end start pin, cascade value when enabled |
| sp_right_oe | output | 1 | Right-end start pin output-enable |
| sp_left_in | input | 1 | Left-end start pin, input value |
| sp_left_out | output | 1 | Left-end start pin, cascade value when enabled |
| sp_left_oe | output | 1 | Left-end start pin output-enable |
| col_strobe | output | 300 | Column sampling strobes, bit c-1 for column c |

## Verification
The start pin is sampled at edge k, and the i-th group of the scan (i from 0) is high during the cycle after edge k+i. The cascade pulse shares the cycle of the last group, and an enable follows `dir_fwd` or `rst` one edge later. The bench drives inputs and samples outputs at the falling edge. Its model advances once per rising edge from the inputs it has just driven, so each comparison lands in the cycle in which the result is due. Directed cases cover long start pulses, mid-scan restarts, reset during a scan and noise on the unselected pin. Random scans mix direction, width mode and pulse length.

// File: rtl/colscan_pkg.sv
package colscan_pkg;

  typedef enum logic {
    DIR_LEFTWARD  = 1'b0,
    DIR_RIGHTWARD = 1'b1
  } scan_dir_e;

  typedef enum logic {
    MODE_REDUCED = 1'b0,
    MODE_FULL    = 1'b1
  } width_mode_e;

  // Stage index of the centred bypass band's first stage.
  function automatic int band_first(input int n_stg, input int band_n);
    return (n_stg - band_n) / 2;
  endfunction

endpackage

// File: rtl/cs_start_sel.sv
// Picks the start pin for the current direction and flags its rising edge.
module cs_start_sel
  import colscan_pkg::*;
(
  input  logic clk,
  input  logic dir_fwd,
  input  logic pin_right_in,
  input  logic pin_left_in,
  output logic start_evt
);

  scan_dir_e dir_e;
  logic      sel_pin;
  logic      sel_q;

  assign dir_e   = scan_dir_e'(dir_fwd);
  assign sel_pin = (dir_e == DIR_RIGHTWARD) ? pin_right_in : pin_left_in;

  // Tracks the pin through reset too, so a level held across reset
  // release is not seen as a new edge.
  always_ff @(posedge clk) begin
    sel_q <= sel_pin;
  end

  assign start_evt = sel_pin & ~sel_q;

endmodule

// File: rtl/cs_order_shift.sv
// One-hot token in scan order (position 0 = first group scanned).
module cs_order_shift #(
  parameter int N_STG  = 100,
  parameter int BAND_N = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_evt,
  input  logic             full_mode,
  output logic [N_STG-1:0] ord_q
);

  localparam int BAND_LO = colscan_pkg::band_first(N_STG, BAND_N);
  localparam int BAND_HI = BAND_LO + BAND_N - 1;

  logic [N_STG-1:0] ord_nxt;

  for (genvar p = 0; p < N_STG; p++) begin : g_pos
    if (p == 0) begin : g_head
      assign ord_nxt[p] = start_evt;
    end else if (p >= BAND_LO && p <= BAND_HI) begin : g_band
      assign ord_nxt[p] = ~start_evt & full_mode & ord_q[p-1];
    end else if (p == BAND_HI + 1) begin : g_rejoin
      assign ord_nxt[p] = ~start_evt &
                          (full_mode ? ord_q[p-1] : ord_q[BAND_LO-1]);
    end else begin : g_plain
      assign ord_nxt[p] = ~start_evt & ord_q[p-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ord_q <= '0;
    else     ord_q <= ord_nxt;
  end

endmodule

// File: rtl/cs_col_map.sv
// Maps scan-order positions to physical stages, mirrors the bypass band,
// and fans each stage out to its column group.
module cs_col_map
  import colscan_pkg::*;
#(
  parameter int N_STG  = 100,
  parameter int GRP    = 3,
  parameter int BAND_N = 4
) (
  input  logic                 dir_fwd,
  input  logic                 full_mode,
  input  logic [N_STG-1:0]     ord_q,
  output logic [N_STG*GRP-1:0] col_strobe
);

  localparam int BAND_LO = band_first(N_STG, BAND_N);
  localparam int BAND_HI = BAND_LO + BAND_N - 1;

  scan_dir_e        dir_e;
  width_mode_e      mode_e;
  logic [N_STG-1:0] phys;
  logic [N_STG-1:0] stg;

  assign dir_e  = scan_dir_e'(dir_fwd);
  assign mode_e = width_mode_e'(full_mode);

  for (genvar s = 0; s < N_STG; s++) begin : g_stage
    assign phys[s] = (dir_e == DIR_RIGHTWARD) ? ord_q[s] : ord_q[N_STG-1-s];

    if (s >= BAND_LO && s <= BAND_HI) begin : g_band
      assign stg[s] = (mode_e == MODE_FULL)      ? phys[s] :
                      (dir_e == DIR_RIGHTWARD)   ? phys[s+BAND_N] :
                                                   phys[s-BAND_N];
    end else begin : g_norm
      assign stg[s] = phys[s];
    end

    assign col_strobe[s*GRP +: GRP] = {GRP{stg[s]}};
  end

endmodule

// File: rtl/cs_cascade.sv
// Output-enables of the two start pins and the far-end cascade value.
module cs_cascade (
  input  logic clk,
  input  logic rst,
  input  logic dir_fwd,
  input  logic last_hit,
  output logic right_out,
  output logic right_oe,
  output logic left_out,
  output logic left_oe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      left_oe  <= 1'b0;
      right_oe <= 1'b0;
    end else begin
      left_oe  <= dir_fwd;
      right_oe <= ~dir_fwd;
    end
  end

  assign left_out  = left_oe  & last_hit;
  assign right_out = right_oe & last_hit;

endmodule

// File: rtl/colscan_seq.sv
module colscan_seq #(
  parameter int N_STG  = 100,
  parameter int GRP    = 3,
  parameter int BAND_N = 4,
  localparam int N_COL = N_STG * GRP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_fwd,
  input  logic             full_mode,
  input  logic             sp_right_in,
  output logic             sp_right_out,
  output logic             sp_right_oe,
  input  logic             sp_left_in,
  output logic             sp_left_out,
  output logic             sp_left_oe,
  output logic [N_COL-1:0] col_strobe
);

  logic             start_evt;
  logic [N_STG-1:0] ord_q;

  cs_start_sel u_start (
    .clk          (clk),
    .dir_fwd      (dir_fwd),
    .pin_right_in (sp_right_in),
    .pin_left_in  (sp_left_in),
    .start_evt    (start_evt)
  );

  cs_order_shift #(.N_STG(N_STG), .BAND_N(BAND_N)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .start_evt (start_evt),
    .full_mode (full_mode),
    .ord_q     (ord_q)
  );

  cs_col_map #(.N_STG(N_STG), .GRP(GRP), .BAND_N(BAND_N)) u_map (
    .dir_fwd    (dir_fwd),
    .full_mode  (full_mode),
    .ord_q      (ord_q),
    .col_strobe (col_strobe)
  );

  cs_cascade u_casc (
    .clk       (clk),
    .rst       (rst),
    .dir_fwd   (dir_fwd),
    .last_hit  (ord_q[N_STG-1]),
    .right_out (sp_right_out),
    .right_oe  (sp_right_oe),
    .left_out  (sp_left_out),
    .left_oe   (sp_left_oe)
  );

endmodule

// File: rtl/cs_chk.sv
module cs_chk #(
  parameter int N_STG  = 100,
  parameter int GRP    = 3,
  parameter int BAND_N = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 dir_fwd,
  input logic                 full_mode,
  input logic                 start_evt,
  input logic [N_STG-1:0]     ord_q,
  input logic [N_STG*GRP-1:0] col_strobe,
  input logic                 sp_left_out,
  input logic                 sp_left_oe,
  input logic                 sp_right_out,
  input logic                 sp_right_oe
);

  localparam int BAND_LO = colscan_pkg::band_first(N_STG, BAND_N);
  localparam int BW      = BAND_N * GRP;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (ord_q == '0 && !sp_left_oe && !sp_right_oe));

  a_r2_start_loads_head: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> ord_q[0]);

  a_r10_restart_drops_old: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> (ord_q[N_STG-1:1] == '0));

  a_r5_single_token: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ord_q));

  a_r6_band_bypassed: assert property (@(posedge clk) disable iff (rst)
    !full_mode |=> (ord_q[BAND_LO +: BAND_N] == '0));

  a_r7_mirror_right: assert property (@(posedge clk) disable iff (rst)
    (!full_mode && dir_fwd) |->
      (col_strobe[BAND_LO*GRP +: BW] == col_strobe[(BAND_LO+BAND_N)*GRP +: BW]));

  a_r8_cascade_on_last: assert property (@(posedge clk) disable iff (rst)
    (ord_q[N_STG-1] && (sp_left_oe || sp_right_oe)) |->
      (sp_left_out || sp_right_out));

  a_r8_cascade_quiet: assert property (@(posedge clk) disable iff (rst)
    !ord_q[N_STG-1] |-> (!sp_left_out && !sp_right_out));

  a_r9_oe_exclusive: assert property (@(posedge clk)
    !(sp_left_oe && sp_right_oe));

  a_r9_oe_follows_dir: assert property (@(posedge clk) disable iff (rst)
    dir_fwd |=> (sp_left_oe || rst));

  a_r9_gated_out: assert property (@(posedge clk)
    ((!sp_left_oe -> !sp_left_out) && (!sp_right_oe -> !sp_right_out)));

endmodule

bind colscan_seq cs_chk #(.N_STG(N_STG), .GRP(GRP), .BAND_N(BAND_N)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .dir_fwd      (dir_fwd),
  .full_mode    (full_mode),
  .start_evt    (start_evt),
  .ord_q        (ord_q),
  .col_strobe   (col_strobe),
  .sp_left_out  (sp_left_out),
  .sp_left_oe   (sp_left_oe),
  .sp_right_out (sp_right_out),
  .sp_right_oe  (sp_right_oe)
);

// File: tb/colscan_seq_bench.sv
module colscan_seq_bench;

  localparam int NS = 100;
  localparam int NC = 300;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dir_fwd = 1'b1;
  logic          full_mode = 1'b1;
  logic          sp_right_in = 1'b0;
  logic          sp_left_in = 1'b0;
  logic          sp_right_out, sp_right_oe, sp_left_out, sp_left_oe;
  logic [NC-1:0] col_strobe;

  colscan_seq u_colscan_seq (
    .clk          (clk),
    .rst          (rst),
    .dir_fwd      (dir_fwd),
    .full_mode    (full_mode),
    .sp_right_in  (sp_right_in),
    .sp_right_out (sp_right_out),
    .sp_right_oe  (sp_right_oe),
    .sp_left_in   (sp_left_in),
    .sp_left_out  (sp_left_out),
    .sp_left_oe   (sp_left_oe),
    .col_strobe   (col_strobe)
  );

  always #4 clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 1'b0;
  string tag      = "R1";

  // Reference state, advanced once per rising edge.
  int    m_idx   = -1;
  bit    m_prev  = 1'b0;
  bit    m_loe   = 1'b0;
  bit    m_roe   = 1'b0;
  bit    m_dir   = 1'b1;
  bit    m_full  = 1'b1;
  bit    m_rst   = 1'b1;
  bit    armed   = 1'b0;

  function automatic int scan_len(input bit full);
    return full ? NS : NS - 4;
  endfunction

  // Expected strobes for scan step idx, from the column rules.
  function automatic logic [NC-1:0] exp_strobes(input int idx, input bit dir,
                                                input bit full);
    logic [NC-1:0] v;
    int ord, st;
    v = '0;
    if (idx >= 0) begin
      ord = (full || idx < 48) ? idx : idx + 4;
      st  = dir ? ord : NS - 1 - ord;
      for (int k = 0; k < 3; k++) v[3*st + k] = 1'b1;
      if (!full) begin
        for (int c = 1; c <= NC; c++) begin
          if (dir && c >= 157 && c <= 168 && v[c-1]) v[c-13] = 1'b1;
          if (!dir && c >= 133 && c <= 144 && v[c-1]) v[c+11] = 1'b1;
        end
      end
    end
    return v;
  endfunction

  task automatic check_now();
    logic [NC-1:0] es;
    bit last, elo, ero;
    string t1;
    es   = exp_strobes(m_idx, m_dir, m_full);
    last = (m_idx == scan_len(m_full) - 1);
    elo  = m_loe && last;
    ero  = m_roe && last;
    t1   = m_rst ? "R1" : tag;
    n_checks++;
    if (col_strobe !== es) begin
      n_fail++;
      $display("FAIL %s strobes: got %h exp %h", t1, col_strobe, es);
    end
    n_checks++;
    if ({sp_left_out, sp_right_out} !== {elo, ero}) begin
      n_fail++;
      $display("FAIL R8 %s cascade l/r: got %b%b exp %b%b", t1,
               sp_left_out, sp_right_out, elo, ero);
    end
    n_checks++;
    if ({sp_left_oe, sp_right_oe} !== {m_loe, m_roe}) begin
      n_fail++;
      $display("FAIL R9 %s enables l/r: got %b%b exp %b%b", t1,
               sp_left_oe, sp_right_oe, m_loe, m_roe);
    end
  endtask

  // One cycle: check at the falling edge, drive, then advance the model.
  task automatic tick(input bit r, input bit d, input bit f,
                      input bit rin, input bit lin);
    bit sel;
    @(negedge clk);
    if (armed) check_now();
    rst = r; dir_fwd = d; full_mode = f; sp_right_in = rin; sp_left_in = lin;
    sel = d ? rin : lin;
    if (r)                   m_idx = -1;
    else if (sel && !m_prev) m_idx = 0;
    else if (m_idx >= 0)     m_idx = (m_idx + 1 >= scan_len(f)) ? -1 : m_idx + 1;
    m_prev = sel;
    m_loe  = !r && d;
    m_roe  = !r && !d;
    m_dir  = d;
    m_full = f;
    m_rst  = r;
    armed  = 1'b1;
  endtask

  // Pulse the selected pin for w cycles, then run n cycles.
  task automatic scan(input bit d, input bit f, input int w, input int n,
                      input bit noise);
    for (int i = 0; i < w; i++)
      tick(0, d, f, d ? 1'b1 : noise & $urandom, d ? noise & $urandom : 1'b1);
    for (int i = 0; i < n; i++)
      tick(0, d, f, d ? 1'b0 : noise & $urandom, d ? noise & $urandom : 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5813));
    for (int i = 0; i < 3; i++) tick(1, 1, 1, 0, 0);
    tag = "R1";
    tick(0, 1, 1, 0, 0);
    tick(0, 1, 1, 0, 0);

    tag = "R3 R5 R8";   scan(1, 1, 1, 104, 0);
    tag = "R4 R5 R8";   scan(0, 1, 1, 104, 0);
    tag = "R6 R7 R3";   scan(1, 0, 1, 100, 0);
    tag = "R6 R7 R4";   scan(0, 0, 1, 100, 0);
    tag = "R2 long";    scan(1, 1, 150, 5, 0);
    tag = "R2 long";    scan(0, 0, 7, 100, 0);
    tag = "R10";        scan(1, 1, 1, 30, 0);
    tag = "R10";        scan(1, 1, 2, 104, 0);
    tag = "R10";        scan(0, 0, 1, 50, 0);
    tag = "R10";        scan(0, 0, 1, 100, 0);
    tag = "R11";        scan(1, 1, 2, 104, 1);
    tag = "R11";        scan(0, 0, 3, 100, 1);
    tag = "R1 midscan"; scan(1, 1, 1, 40, 0);
    tick(1, 1, 1, 0, 0);
    tick(0, 1, 1, 0, 0);
    tick(0, 1, 1, 0, 0);
    tag = "R2 held-through-reset";
    tick(1, 0, 1, 0, 1);
    tick(0, 0, 1, 0, 1);
    for (int i = 0; i < 5; i++) tick(0, 0, 1, 0, 1);
    tick(0, 0, 1, 0, 0);
    tick(0, 1, 1, 0, 0);
    tick(0, 1, 1, 0, 0);

    for (int s = 0; s < 30; s++) begin
      bit d, f, nz;
      int w, n;
      d  = $urandom_range(1, 0);
      f  = $urandom_range(1, 0);
      nz = $urandom_range(1, 0);
      w  = $urandom_range(4, 1);
      n  = $urandom_range(110, 20);
      tag = d ? (f ? "R3 rand" : "R6 R7 rand right") : (f ? "R4 rand" : "R6 R7 rand left");
      for (int i = 0; i < 3; i++) tick(0, d, f, 0, 0);
      scan(d, f, w, n, nz);
      for (int i = 0; i < 110; i++) tick(0, d, f, 0, 0);
    end
    tick(0, 1, 1, 0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule